// File: doc/BRIEF.md
# Host Port Word-Assembling Bridge

This bridge lets an external host with a 16-bit data bus reach a 32-bit internal memory. The host uses single-cycle strobes and picks one of four access targets: the data window at a fixed address, the data window with address auto-increment, the address register, or the control register. Each 32-bit internal word is moved as two host half-words. A read is launched by the first half-word. A write goes out once the second half-word arrives.

The bridge keeps the whole transfer context: the memory address and the direction. It gives the memory arbiter a plain request made of direction, address and write data, and holds that request until the arbiter grants it. While a request waits, the host sees a not-ready indication and its strobes are not accepted.

Top module: `hostport_bridge`

## Requirements
- R1: After reset, hp_ready is 1, mq_req is 0, hp_rdata is 0, and the address and control registers read as 0.
- R2: An accepted write with hp_sel=2 loads address bits 15:0 when hp_half=0 and bits 31:16 when hp_half=1. A read with hp_sel=2 returns the same half.
- R3: hp_sel=3 selects the control register. Only bit 0 is stored. A read returns bit 0 with all upper bits zero.
- R4: A data read (hp_sel 0 or 1) with hp_half=0 raises one request with mq_wr=0 and mq_addr equal to the address register. A data read with hp_half=1 raises no request and returns the other half of the word latched by the last internal read.
- R5: A data write with hp_half=0 only buffers the half-word and raises no request. A data write with hp_half=1 raises one request with mq_wr=1 and the two half-words joined into mq_wdata.
- R6: With control bit 0 clear, the first half-word (hp_half=0) is bits 15:0 of the memory word. With control bit 0 set, the first half-word is bits 31:16. This applies to reads and writes.
- R7: mq_req, mq_wr, mq_addr and mq_wdata stay unchanged while mq_req is high and mq_gnt is low. mq_req drops in the cycle after mq_gnt is sampled high.
- R8: hp_ready goes low in the cycle after a launching strobe and returns high in the cycle after the grant. When the grant comes D cycles after the request rises, hp_ready is low for D+1 cycles. After a first-half read, hp_rdata is valid once hp_ready is high again.
- R9: A strobe that arrives while hp_ready is low has no effect.
- R10: A transfer made through hp_sel=1 adds 4 to the address register when it is granted. hp_sel=0 transfers leave the address register unchanged.
- R11: mq_req rises only in the cycle after a launching host strobe. An idle host produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_stb | input | 1 | Host access strobe, one cycle per access |
| hp_rnw | input | 1 | 1 = host read, 0 = host write |
| hp_sel | input | 2 | Target: 0 data, 1 data with auto-increment, 2 address, 3 control |
| hp_half | input | 1 | 0 = first half-word, 1 = second half-word |
| hp_wdata | input | 16 | Host write data |
| hp_rdata | output | 16 | Host read data |
| hp_ready | output | 1 | Low while an internal request is pending |
| mq_req | output | 1 | Internal transfer request |
| mq_wr | output | 1 | 1 = write to memory, 0 = read from memory |
| mq_addr | output | 32 | Internal byte address |
| mq_wdata | output | 32 | Internal write word |
| mq_gnt | input | 1 | Grant from the arbiter; low means wait |
| mq_rdata | input | 32 | Read word, valid in the grant cycle |

## Verification
The bench runs reads and writes in both half-word orders. Known data such as 0xCAFEBEEF shows whether the halves end up in the right positions or swapped. The arbiter model uses grant delays of 0, 1, 3 and 5 cycles, which makes stall length, request holding and the timing of the returned data visible. Fixed-address and auto-increment accesses run over the same words, so a missing or spurious increment is caught. A register write issued during a stall shows whether a strobe that should be ignored leaks through.

// File: rtl/hpb_pkg.sv
package hpb_pkg;
    localparam int HALF_W    = 16;
    localparam int WORD_W    = 2 * HALF_W;
    localparam int BYTE_STEP = WORD_W / 8;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_DATA     = 2'd0,
        SEL_DATA_INC = 2'd1,
        SEL_ADDR     = 2'd2,
        SEL_CTL      = 2'd3
    } hsel_e;

    typedef struct packed {
        logic  wr;
        word_t addr;
        word_t data;
        logic  inc;
    } xfer_t;

    // Joins two host half-words into one memory word in the selected order.
    function automatic word_t join_halves(half_t first, half_t second, logic hi_first);
        return hi_first ? {first, second} : {second, first};
    endfunction

    // Picks the half of a memory word that belongs to a given host slot.
    function automatic half_t pick_half(word_t w, logic second, logic hi_first);
        return (second ^ hi_first) ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction
endpackage

// File: rtl/hpb_regs.sv
module hpb_regs
    import hpb_pkg::*;
#(
    parameter int STEP = BYTE_STEP
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  addr_we_lo,
    input  logic  addr_we_hi,
    input  logic  ctl_we,
    input  half_t wdata,
    input  logic  inc,
    output word_t addr_q,
    output logic  hi_first_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            hi_first_q <= 1'b0;
        end else begin
            if (inc) begin
                addr_q <= addr_q + word_t'(STEP);
            end else begin
                if (addr_we_lo) addr_q[HALF_W-1:0]      <= wdata;
                if (addr_we_hi) addr_q[WORD_W-1:HALF_W] <= wdata;
            end
            if (ctl_we) hi_first_q <= wdata[0];
        end
    end

    assert_step_on_grant_R10: assert property (@(posedge clk) disable iff (rst)
        inc |=> addr_q == $past(addr_q) + word_t'(STEP));
endmodule

// File: rtl/hpb_pack.sv
module hpb_pack
    import hpb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  first_we,
    input  half_t wdata,
    input  logic  hi_first,
    input  logic  cap_rd,
    input  word_t mem_rdata,
    output word_t wr_word,
    output word_t rd_buf_q
);
    half_t first_buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_buf_q <= '0;
            rd_buf_q    <= '0;
        end else begin
            if (first_we) first_buf_q <= wdata;
            if (cap_rd)   rd_buf_q    <= mem_rdata;
        end
    end

    // The second half arrives on the host bus in the cycle the write launches.
    always_comb wr_word = join_halves(first_buf_q, wdata, hi_first);
endmodule

// File: rtl/hpb_req.sv
module hpb_req
    import hpb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  launch,
    input  xfer_t launch_x,
    input  logic  gnt,
    output logic  req_q,
    output xfer_t cur_q,
    output logic  done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            cur_q <= '0;
        end else if (req_q && gnt) begin
            req_q <= 1'b0;
        end else if (launch && !req_q) begin
            req_q <= 1'b1;
            cur_q <= launch_x;
        end
    end

    always_comb done = req_q && gnt;

    assert_hold_while_wait_R7: assert property (@(posedge clk) disable iff (rst)
        (req_q && !gnt) |=> (req_q && $stable(cur_q)));
    assert_drop_after_grant_R7: assert property (@(posedge clk) disable iff (rst)
        (req_q && gnt) |=> !req_q);
    assert_rise_needs_launch_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(req_q) |-> $past(launch));
endmodule

// File: rtl/hostport_bridge.sv
module hostport_bridge
    import hpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hp_stb,
    input  logic              hp_rnw,
    input  logic [1:0]        hp_sel,
    input  logic              hp_half,
    input  logic [HALF_W-1:0] hp_wdata,
    output logic [HALF_W-1:0] hp_rdata,
    output logic              hp_ready,
    output logic              mq_req,
    output logic              mq_wr,
    output logic [WORD_W-1:0] mq_addr,
    output logic [WORD_W-1:0] mq_wdata,
    input  logic              mq_gnt,
    input  logic [WORD_W-1:0] mq_rdata
);
    hsel_e sel;
    logic  accept, is_data, launch, first_we, done;
    logic  req_q, hi_first_q;
    word_t addr_q, wr_word, rd_buf_q;
    xfer_t launch_x, cur_q;

    always_comb begin
        sel      = hsel_e'(hp_sel);
        accept   = hp_stb && hp_ready;
        is_data  = (sel == SEL_DATA) || (sel == SEL_DATA_INC);
        launch   = accept && is_data && (hp_rnw ? !hp_half : hp_half);
        first_we = accept && is_data && !hp_rnw && !hp_half;
        launch_x = '{wr: !hp_rnw, addr: addr_q, data: wr_word, inc: (sel == SEL_DATA_INC)};
    end

    hpb_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .addr_we_lo (accept && !hp_rnw && sel == SEL_ADDR && !hp_half),
        .addr_we_hi (accept && !hp_rnw && sel == SEL_ADDR && hp_half),
        .ctl_we     (accept && !hp_rnw && sel == SEL_CTL),
        .wdata      (hp_wdata),
        .inc        (done && cur_q.inc),
        .addr_q     (addr_q),
        .hi_first_q (hi_first_q)
    );

    hpb_pack u_pack (
        .clk       (clk),
        .rst       (rst),
        .first_we  (first_we),
        .wdata     (hp_wdata),
        .hi_first  (hi_first_q),
        .cap_rd    (done && !cur_q.wr),
        .mem_rdata (mq_rdata),
        .wr_word   (wr_word),
        .rd_buf_q  (rd_buf_q)
    );

    hpb_req u_req (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .launch_x (launch_x),
        .gnt      (mq_gnt),
        .req_q    (req_q),
        .cur_q    (cur_q),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hp_rdata <= '0;
        end else if (done && !cur_q.wr) begin
            hp_rdata <= pick_half(mq_rdata, 1'b0, hi_first_q);
        end else if (accept && hp_rnw) begin
            unique case (sel)
                SEL_ADDR: hp_rdata <= hp_half ? addr_q[WORD_W-1:HALF_W] : addr_q[HALF_W-1:0];
                SEL_CTL:  hp_rdata <= {{(HALF_W-1){1'b0}}, hi_first_q};
                default:  if (hp_half) hp_rdata <= pick_half(rd_buf_q, 1'b1, hi_first_q);
            endcase
        end
    end

    always_comb begin
        hp_ready = !req_q;
        mq_req   = req_q;
        mq_wr    = cur_q.wr;
        mq_addr  = cur_q.addr;
        mq_wdata = cur_q.data;
    end

    assert_stall_after_launch_R8: assert property (@(posedge clk) disable iff (rst)
        launch |=> !hp_ready);
    assert_ready_after_grant_R8: assert property (@(posedge clk) disable iff (rst)
        (mq_req && mq_gnt) |=> hp_ready);
    assert_stalled_strobe_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (hp_stb && !hp_ready && !mq_gnt) |=> ($stable(addr_q) && $stable(hi_first_q)));
    assert_req_addr_from_reg_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(mq_req) |-> mq_addr == $past(addr_q));
endmodule

// File: tb/hostport_bridge_tb_top.sv
module hostport_bridge_tb_top;
    import hpb_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic hp_stb = 1'b0, hp_rnw = 1'b0, hp_half = 1'b0;
    logic [1:0] hp_sel = 2'd0;
    half_t hp_wdata = '0, hp_rdata;
    logic hp_ready, mq_req, mq_wr, mq_gnt;
    word_t mq_addr, mq_wdata, mq_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    hostport_bridge dut_i (
        .clk(clk), .rst(rst), .hp_stb(hp_stb), .hp_rnw(hp_rnw), .hp_sel(hp_sel),
        .hp_half(hp_half), .hp_wdata(hp_wdata), .hp_rdata(hp_rdata), .hp_ready(hp_ready),
        .mq_req(mq_req), .mq_wr(mq_wr), .mq_addr(mq_addr), .mq_wdata(mq_wdata),
        .mq_gnt(mq_gnt), .mq_rdata(mq_rdata)
    );

    function automatic word_t seed_val(int i);
        return word_t'(i) * 32'h0103_0507 ^ 32'h5A5A_0000;
    endfunction

    // Arbiter and memory model
    word_t mem [64];
    word_t ref_mem [64];
    int gnt_delay = 0;
    int wait_cnt = 0;
    assign mq_gnt   = mq_req && (wait_cnt >= gnt_delay);
    assign mq_rdata = mem[mq_addr[7:2]];

    always @(posedge clk) begin
        if (rst) begin
            wait_cnt <= 0;
            for (int i = 0; i < 64; i++) mem[i] <= seed_val(i);
        end else begin
            wait_cnt <= (mq_req && !mq_gnt) ? wait_cnt + 1 : 0;
            if (mq_req && mq_gnt && mq_wr) mem[mq_addr[7:2]] <= mq_wdata;
        end
    end

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic check(bit ok, string tag, word_t act, word_t exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard of expected internal transfers
    typedef struct {
        bit    wr;
        word_t addr;
        word_t data;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    int held = 0;

    always @(negedge clk) begin
        if (!rst && mq_req) begin
            held++;
            if (mq_gnt) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected request", mq_addr, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mq_wr == e.wr, {e.tag, " direction"}, word_t'(mq_wr), word_t'(e.wr));
                    check(mq_addr == e.addr, {e.tag, " address"}, mq_addr, e.addr);
                    if (e.wr) check(mq_wdata == e.data, {e.tag, " write word"}, mq_wdata, e.data);
                    check(held == gnt_delay + 1, "R7 request held until grant",
                          word_t'(held), word_t'(gnt_delay + 1));
                end
                held = 0;
            end
        end
    end

    task automatic host(input hsel_e sel, input bit half, input bit rnw, input half_t d,
                        output half_t rd, output int stall);
        @(negedge clk);
        while (!hp_ready) @(negedge clk);
        hp_stb = 1'b1; hp_sel = sel; hp_half = half; hp_rnw = rnw; hp_wdata = d;
        @(negedge clk);
        hp_stb = 1'b0;
        stall = 0;
        while (!hp_ready) begin
            stall++;
            @(negedge clk);
        end
        rd = hp_rdata;
    endtask

    task automatic push(bit wr, word_t a, word_t d, string tag);
        exp_t e;
        e.wr = wr; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic set_addr(word_t a);
        half_t r; int s;
        host(SEL_ADDR, 1'b0, 1'b0, a[15:0], r, s);
        host(SEL_ADDR, 1'b1, 1'b0, a[31:16], r, s);
    endtask

    task automatic rd_addr(output word_t a);
        half_t lo, hi; int s;
        host(SEL_ADDR, 1'b0, 1'b1, '0, lo, s);
        host(SEL_ADDR, 1'b1, 1'b1, '0, hi, s);
        a = {hi, lo};
    endtask

    initial begin
        half_t r; int s; word_t a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(hp_ready == 1'b1, "R1 ready after reset", word_t'(hp_ready), 1);
        check(mq_req == 1'b0, "R1 no request after reset", word_t'(mq_req), 0);
        check(hp_rdata == '0, "R1 read data after reset", word_t'(hp_rdata), 0);
        rd_addr(a);
        check(a == '0, "R1 address after reset", a, 0);
        host(SEL_CTL, 1'b0, 1'b1, '0, r, s);
        check(r == '0, "R1 control after reset", word_t'(r), 0);

        // R2 address register halves
        set_addr(32'hABCD_0010);
        rd_addr(a);
        check(a == 32'hABCD_0010, "R2 address readback", a, 32'hABCD_0010);
        host(SEL_ADDR, 1'b1, 1'b0, 16'h0000, r, s);
        rd_addr(a);
        check(a == 32'h0000_0010, "R2 upper half alone", a, 32'h0000_0010);

        // R3 control register keeps bit 0 only
        host(SEL_CTL, 1'b0, 1'b0, 16'hFFFE, r, s);
        host(SEL_CTL, 1'b0, 1'b1, '0, r, s);
        check(r == 16'h0000, "R3 control bit0 clear", word_t'(r), 0);
        host(SEL_CTL, 1'b0, 1'b0, 16'hFFFF, r, s);
        host(SEL_CTL, 1'b0, 1'b1, '0, r, s);
        check(r == 16'h0001, "R3 control upper bits zero", word_t'(r), 1);
        host(SEL_CTL, 1'b0, 1'b0, 16'h0000, r, s);

        // R4 read: first half launches, second half from latch
        for (int i = 0; i < 64; i++) ref_mem[i] = seed_val(i);
        push(1'b0, 32'h10, '0, "R4 read request");
        host(SEL_DATA, 1'b0, 1'b1, '0, r, s);
        check(r == ref_mem[4][15:0], "R4 first half read", word_t'(r), word_t'(ref_mem[4][15:0]));
        check(s == 1, "R8 stall with zero delay", word_t'(s), 1);
        host(SEL_DATA, 1'b1, 1'b1, '0, r, s);
        check(r == ref_mem[4][31:16], "R4 second half from latch", word_t'(r), word_t'(ref_mem[4][31:16]));
        check(s == 0, "R4 second half no stall", word_t'(s), 0);

        // R5 write: buffered first half, request on second
        host(SEL_DATA, 1'b0, 1'b0, 16'hBEEF, r, s);
        check(mq_req == 1'b0 && s == 0, "R5 first half no request", word_t'(mq_req), 0);
        push(1'b1, 32'h10, 32'hCAFE_BEEF, "R5 write request");
        host(SEL_DATA, 1'b1, 1'b0, 16'hCAFE, r, s);
        ref_mem[4] = 32'hCAFE_BEEF;

        // R6 upper half first
        host(SEL_CTL, 1'b0, 1'b0, 16'h0001, r, s);
        push(1'b0, 32'h10, '0, "R6 read request");
        host(SEL_DATA, 1'b0, 1'b1, '0, r, s);
        check(r == 16'hCAFE, "R6 upper-first read first half", word_t'(r), 32'hCAFE);
        host(SEL_DATA, 1'b1, 1'b1, '0, r, s);
        check(r == 16'hBEEF, "R6 upper-first read second half", word_t'(r), 32'hBEEF);
        host(SEL_DATA, 1'b0, 1'b0, 16'h1111, r, s);
        push(1'b1, 32'h10, 32'h1111_2222, "R6 upper-first write");
        host(SEL_DATA, 1'b1, 1'b0, 16'h2222, r, s);
        host(SEL_CTL, 1'b0, 1'b0, 16'h0000, r, s);
        push(1'b0, 32'h10, '0, "R6 readback request");
        host(SEL_DATA, 1'b0, 1'b1, '0, r, s);
        check(r == 16'h2222, "R6 lower-first readback", word_t'(r), 32'h2222);

        // R8 stall length with delay 3
        gnt_delay = 3;
        push(1'b0, 32'h10, '0, "R8 delayed read");
        host(SEL_DATA, 1'b0, 1'b1, '0, r, s);
        check(s == 4, "R8 stall length", word_t'(s), 4);
        check(r == 16'h2222, "R8 data after stall", word_t'(r), 32'h2222);

        // R9 strobe during stall is ignored
        gnt_delay = 5;
        push(1'b0, 32'h10, '0, "R9 stalled read");
        @(negedge clk);
        hp_stb = 1'b1; hp_sel = SEL_DATA; hp_half = 1'b0; hp_rnw = 1'b1;
        @(negedge clk);
        hp_sel = SEL_ADDR; hp_half = 1'b1; hp_rnw = 1'b0; hp_wdata = 16'hFFFF;
        check(hp_ready == 1'b0, "R9 stall present", word_t'(hp_ready), 0);
        @(negedge clk);
        hp_stb = 1'b0;
        while (!hp_ready) @(negedge clk);
        rd_addr(a);
        check(a == 32'h10, "R9 address untouched by stalled strobe", a, 32'h10);

        // R10 auto-increment
        gnt_delay = 1;
        set_addr(32'h20);
        push(1'b0, 32'h20, '0, "R10 inc read");
        host(SEL_DATA_INC, 1'b0, 1'b1, '0, r, s);
        check(r == ref_mem[8][15:0], "R10 inc read data", word_t'(r), word_t'(ref_mem[8][15:0]));
        host(SEL_DATA_INC, 1'b1, 1'b1, '0, r, s);
        rd_addr(a);
        check(a == 32'h24, "R10 step after read", a, 32'h24);
        host(SEL_DATA_INC, 1'b0, 1'b0, 16'h5555, r, s);
        push(1'b1, 32'h24, 32'h6666_5555, "R10 inc write");
        host(SEL_DATA_INC, 1'b1, 1'b0, 16'h6666, r, s);
        rd_addr(a);
        check(a == 32'h28, "R10 step after write", a, 32'h28);
        host(SEL_DATA, 1'b0, 1'b0, 16'h7777, r, s);
        push(1'b1, 32'h28, 32'h8888_7777, "R10 fixed write");
        host(SEL_DATA, 1'b1, 1'b0, 16'h8888, r, s);
        rd_addr(a);
        check(a == 32'h28, "R10 fixed access keeps address", a, 32'h28);

        // R11 idle host raises no request
        s = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mq_req) s++;
        end
        check(s == 0, "R11 idle produces no request", word_t'(s), 0);
        check(exp_q.size() == 0, "R11 all expected requests seen", word_t'(exp_q.size()), 0);

        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", '0, '0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule